// File: doc/BRIEF.md
# Sensor Temperature Contrast Controller

This block closes a heating loop around a swept thermal fingerprint sensor. Every frame read from the sensor carries a 4-bit chip temperature code in its trailing synchronization column. The readout logic upstream extracts that code and presents it with a one-cycle frame strobe. It also supplies a flag that says the image contrast has become too weak. When that flag is set, this controller raises the sensor's heater enable. It keeps the heater on until the chip has warmed by a fixed number of code steps, one step being about 1.4 K. The controller also reports the signed temperature offset from the code's midpoint.

The controller has two states. In **IDLE** the heater is off. The transition **START** (IDLE to HEAT) happens on a frame strobe when contrast is low, the code is not saturated and the readout is not held off. On START the controller captures the code as its baseline. In **HEAT** the heater is on. Four transitions return to IDLE. **REACHED** fires when a strobed code is at least baseline plus the rise target. **SATURATED** fires when a strobed code is 15. **EXPIRED** fires when the heating has seen as many frames as the timeout limit, and it also sets an error flag. **ABORT** fires when the readout controller is in nap or reset. Heating lasts seconds, so the timeout is counted in frames rather than in clock cycles.

Top module: `thermal_contrast_ctrl`

## Requirements
- R1: After reset, heater_en, heating and timeout_err are 0 and temp_delta is 0.
- R2: A strobe with low_contrast=1, hold_off=0 and code not equal to 15 moves IDLE to HEAT. heating and heater_en are 1 from the next cycle, and timeout_err is cleared.
- R3: In HEAT, a strobed code greater than or equal to baseline+2 returns to IDLE without an error. The baseline is the code strobed at START.
- R4: Code 15 is saturated. In HEAT it ends heating at once, and in IDLE it never starts heating.
- R5: Each strobe in HEAT that meets no stop condition counts one frame. When the count reaches timeout_frames, the block returns to IDLE and sets timeout_err. timeout_err stays set until the next START.
- R6: While hold_off=1, heater_en is 0 in the same cycle. Heating ends on the next edge, and no START can occur.
- R7: temp_delta is a signed 5-bit value equal to code minus 8. It is updated only on a frame strobe.
- R8: Changes on temp_code and low_contrast without a frame strobe have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle strobe marking a new frame's temperature code |
| temp_code | input | 4 | Chip temperature code from the frame's trailing column |
| low_contrast | input | 1 | Image contrast too weak |
| hold_off | input | 1 | Readout controller in nap or reset |
| timeout_frames | input | 8 | Frame limit for one heating run |
| heater_en | output | 1 | Sensor heater enable |
| heating | output | 1 | Controller is in HEAT |
| timeout_err | output | 1 | Last heating run expired without reaching target |
| temp_delta | output | 5 | Signed code offset from midpoint 8 |

## Verification
The checker covers the following on every cycle:
- heater_en is never high during hold_off.
- Heating begins only after a strobe with low contrast.
- A saturated strobed code always ends heating.
- timeout_err rises only out of HEAT.
- temp_delta holds still between strobes.

Three behaviours show only in the bench's frame sequences:
- The baseline-plus-two target, including a baseline of 0 and a warm start at 14.
- Counting frames up to the timeout limit.
- The error flag staying set and then clearing on the next START.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HEAT = 1'b1
    } heat_state_e;

    localparam int CODE_W   = 4;
    localparam int CODE_MID = 8;
endpackage

// File: rtl/tcc_frame_timer.sv
module tcc_frame_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [TMO_W-1:0] limit,
    output logic             hit
);
    logic [TMO_W-1:0] cnt;
    logic [TMO_W:0]   next_cnt;

    assign next_cnt = {1'b0, cnt} + 1'b1;
    assign hit      = step && (next_cnt >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step && !hit) begin
            cnt <= next_cnt[TMO_W-1:0];
        end
    end
endmodule

// File: rtl/tcc_delta.sv
module tcc_delta #(
    parameter int CODE_W = 4,
    parameter int MID    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [CODE_W-1:0]   code,
    output logic signed [CODE_W:0] delta
);
    localparam logic signed [CODE_W:0] MID_S = (CODE_W+1)'(MID);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            delta <= '0;
        end else if (load) begin
            delta <= $signed({1'b0, code}) - MID_S;
        end
    end
endmodule

// File: rtl/tcc_fsm.sv
module tcc_fsm
    import tcc_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int RISE   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [CODE_W-1:0] code,
    input  logic              low_contrast,
    input  logic              hold_off,
    input  logic              tmo_hit,
    output logic              timer_clear,
    output logic              timer_step,
    output logic              heater_en,
    output logic              heating,
    output logic              timeout_err
);
    localparam logic [CODE_W-1:0] SAT_CODE = {CODE_W{1'b1}};
    localparam logic [CODE_W:0]   RISE_V   = (CODE_W+1)'(RISE);

    heat_state_e       state, state_nx;
    logic [CODE_W-1:0] baseline;
    logic              start_ok, saturated, reached, live_frame;

    assign saturated  = (code == SAT_CODE);
    assign reached    = ({1'b0, code} >= ({1'b0, baseline} + RISE_V));
    assign start_ok   = frame_stb && low_contrast && !hold_off && !saturated;
    assign live_frame = frame_stb && !hold_off;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_ok) state_nx = ST_HEAT;
            ST_HEAT: begin
                if (hold_off)
                    state_nx = ST_IDLE;
                else if (frame_stb && (saturated || reached || tmo_hit))
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            baseline    <= '0;
            timeout_err <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start_ok) begin
                baseline    <= code;
                timeout_err <= 1'b0;
            end else if (state == ST_HEAT && live_frame && !saturated
                         && !reached && tmo_hit) begin
                timeout_err <= 1'b1;
            end
        end
    end

    always_comb begin
        heating     = (state == ST_HEAT);
        heater_en   = heating && !hold_off;
        timer_clear = (state == ST_IDLE);
        timer_step  = heating && live_frame && !saturated && !reached;
    end
endmodule

// File: rtl/thermal_contrast_ctrl.sv
module thermal_contrast_ctrl #(
    parameter int CODE_W = 4,
    parameter int TMO_W  = 8,
    parameter int RISE   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_stb,
    input  logic [CODE_W-1:0]       temp_code,
    input  logic                    low_contrast,
    input  logic                    hold_off,
    input  logic [TMO_W-1:0]        timeout_frames,
    output logic                    heater_en,
    output logic                    heating,
    output logic                    timeout_err,
    output logic signed [CODE_W:0]  temp_delta
);
    logic t_clear, t_step, t_hit;

    tcc_frame_timer #(.TMO_W(TMO_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (t_clear),
        .step  (t_step),
        .limit (timeout_frames),
        .hit   (t_hit)
    );

    tcc_delta #(.CODE_W(CODE_W), .MID(tcc_pkg::CODE_MID)) u_delta (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_stb),
        .code  (temp_code),
        .delta (temp_delta)
    );

    tcc_fsm #(.CODE_W(CODE_W), .RISE(RISE)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_stb    (frame_stb),
        .code         (temp_code),
        .low_contrast (low_contrast),
        .hold_off     (hold_off),
        .tmo_hit      (t_hit),
        .timer_clear  (t_clear),
        .timer_step   (t_step),
        .heater_en    (heater_en),
        .heating      (heating),
        .timeout_err  (timeout_err)
    );
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
    parameter int CODE_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   frame_stb,
    input logic [CODE_W-1:0]      temp_code,
    input logic                   low_contrast,
    input logic                   hold_off,
    input logic                   heater_en,
    input logic                   heating,
    input logic                   timeout_err,
    input logic signed [CODE_W:0] temp_delta
);
    p_no_heat_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_off |-> !heater_en);

    p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(heating) |-> $past(frame_stb && low_contrast && !hold_off));

    p_sat_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (heating && frame_stb && temp_code == {CODE_W{1'b1}}) |=> !heating);

    p_err_from_heat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> $past(heating));

    p_delta_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(temp_delta));
endmodule

bind thermal_contrast_ctrl tcc_checker #(.CODE_W(CODE_W)) u_tcc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_stb    (frame_stb),
    .temp_code    (temp_code),
    .low_contrast (low_contrast),
    .hold_off     (hold_off),
    .heater_en    (heater_en),
    .heating      (heating),
    .timeout_err  (timeout_err),
    .temp_delta   (temp_delta)
);

// File: tb/tb_thermal_contrast_ctrl.sv
`timescale 1ns/1ps
module tb_thermal_contrast_ctrl;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_stb = 1'b0;
    logic [3:0]       temp_code = 4'd8;
    logic             low_contrast = 1'b0;
    logic             hold_off = 1'b0;
    logic [7:0]       timeout_frames = 8'd4;
    logic             heater_en, heating, timeout_err;
    logic signed [4:0] temp_delta;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    thermal_contrast_ctrl dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .temp_code(temp_code),
        .low_contrast(low_contrast), .hold_off(hold_off),
        .timeout_frames(timeout_frames), .heater_en(heater_en),
        .heating(heating), .timeout_err(timeout_err), .temp_delta(temp_delta)
    );

    // {code, low_contrast, exp_heat, exp_err, exp_delta}; timeout = 4 frames
    localparam logic [11:0] VEC [15] = '{
        {4'd8,  1'b0, 1'b0, 1'b0, 5'h00},  // idle, no demand
        {4'd8,  1'b1, 1'b1, 1'b0, 5'h00},  // R2 start, base 8
        {4'd9,  1'b1, 1'b1, 1'b0, 5'h01},
        {4'd10, 1'b0, 1'b0, 1'b0, 5'h02},  // R3 reached 8+2
        {4'd7,  1'b1, 1'b1, 1'b0, 5'h1F},  // R2 start, base 7
        {4'd7,  1'b1, 1'b1, 1'b0, 5'h1F},
        {4'd8,  1'b1, 1'b1, 1'b0, 5'h00},
        {4'd8,  1'b1, 1'b1, 1'b0, 5'h00},
        {4'd8,  1'b1, 1'b0, 1'b1, 5'h00},  // R5 expired
        {4'd15, 1'b1, 1'b0, 1'b1, 5'h07},  // R4 no start, err sticky
        {4'd14, 1'b1, 1'b1, 1'b0, 5'h06},  // R2 start clears err
        {4'd15, 1'b1, 1'b0, 1'b0, 5'h07},  // R4 saturated stop
        {4'd0,  1'b1, 1'b1, 1'b0, 5'h18},  // start at base 0
        {4'd1,  1'b1, 1'b1, 1'b0, 5'h19},
        {4'd3,  1'b0, 1'b0, 1'b0, 5'h1B}   // R3 above target
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [3:0] c, input logic lc);
        @(negedge clk);
        temp_code = c; low_contrast = lc; frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 heater", 32'(heater_en), 0);
        check("R1 heating", 32'(heating), 0);
        check("R1 err", 32'(timeout_err), 0);
        check("R1 delta", 32'(temp_delta), 0);
        rst_n = 1'b1;

        for (int i = 0; i < 15; i++) begin
            frame(VEC[i][11:8], VEC[i][7]);
            check($sformatf("R2/R3/R4/R5 vec%0d heating", i), 32'(heating), 32'(VEC[i][6]));
            check($sformatf("R5 vec%0d err", i), 32'(timeout_err), 32'(VEC[i][5]));
            check($sformatf("R7 vec%0d delta", i), 32'(temp_delta[4:0]), 32'(VEC[i][4:0]));
        end

        // R6: hold_off drops heater at once, ends heating, blocks start
        frame(4'd8, 1'b1);
        check("R6 pre heating", 32'(heating), 1);
        hold_off = 1'b1;
        #1;
        check("R6 heater same cycle", 32'(heater_en), 0);
        @(negedge clk);
        check("R6 heating ended", 32'(heating), 0);
        frame(4'd8, 1'b1);
        check("R6 no start", 32'(heating), 0);
        check("R6 no err", 32'(timeout_err), 0);
        hold_off = 1'b0;

        // R8: no strobe, inputs ignored
        @(negedge clk);
        temp_code = 4'd2; low_contrast = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 no start", 32'(heating), 0);
        check("R8 delta held", 32'(temp_delta), 0);

        // R1: reset during heating
        frame(4'd5, 1'b1);
        check("R1 pre heating", 32'(heating), 1);
        rst_n = 1'b0;
        #1;
        check("R1 async heater", 32'(heater_en), 0);
        check("R1 async delta", 32'(temp_delta), 0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule